// File: doc/BRIEF.md
# Programmable Broadcast-Command Delay Line

This block holds back a per-bunch-crossing broadcast command by a programmable number of bunch crossings (BX). Each input cycle is one BX. Every cycle the block stores a word holding a valid strobe, a small command code and a bunch-counter tag. The tag comes from a free-running orbit counter inside the block. The word comes out again a set number of cycles later. Because the command and its tag travel together, downstream counter resets stay aligned with the delayed data stream.

The delay can be loaded directly as a 6-bit BX count. It can also be loaded from a latency given in frames, where six frames make one BX, plus a signed BX offset. Any value below five BX is treated as five. Whenever the delay in force changes, the output stays silent until the line has refilled at the new length. Storage is a 64-entry circular buffer with one synchronous read per cycle, so it maps onto block RAM.

Top module: `bcmd_delay_line`

## Requirements
- R1: A command sampled with `cmd_vld` high at clock edge k appears on `out_vld`/`out_code` right after edge k+D, where D is the delay in force, provided no blanking applies.
- R2: Every delayed command carries on `out_bx` the bunch-counter value that was current when it was sampled.
- R3: The bunch counter is 0 in the first cycle after reset, advances by one per cycle, and wraps from 3563 to 0.
- R4: The delay in force is the programmed 6-bit value when that value is 5 or more, and 5 BX otherwise (0 through 4 all give 5; 63 gives 63).
- R5: A latency write loads floor(frames/6) plus the signed offset. A negative result gives the minimum delay, and a result above 63 gives 63.
- R6: Out of reset, the delay is the one derived from the default latency parameter (235 frames with offset 0, giving 39 BX). `out_vld` is low during reset and for the first D edges after it.
- R7: When a write changes the delay in force at edge c, `out_vld` is low after edges c+1 through c+Dnew. No command sampled at or before edge c is emitted after that edge.
- R8: A write that leaves the delay in force unchanged causes no blanking, and the command stream continues without a gap.
- R9: If a direct write and a latency write occur in the same cycle, the direct write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | BX-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Broadcast command present this BX |
| cmd_code | input | CODE_W | Command code |
| dly_wr | input | 1 | Direct delay write strobe |
| dly_wdata | input | DLY_W | Delay value in BX |
| lat_wr | input | 1 | Latency-based delay write strobe |
| lat_frames | input | LAT_W | Latency in frames |
| lat_ofs | input | OFS_W | Signed offset in BX |
| out_vld | output | 1 | Delayed command present |
| out_code | output | CODE_W | Delayed command code |
| out_bx | output | BX_W | Bunch-counter tag of the delayed command |

## Verification
Commands are sent on random BX values at densities from sparse to nearly every cycle. The sparse case separates an off-by-one in timing from a correct line, because each pulse is isolated. The dense case exposes any mixing of neighbouring entries. The delay is moved through the default, 0, 4, 5, 63 and several latency conversions, including a negative saturation, an upper saturation and a same-cycle write conflict. These separate the clamping, the blanking window and write priority. One long stretch runs past a full orbit, so a wrong tag wrap shows up on the delayed output.

// File: rtl/bcmd_pkg.sv
package bcmd_pkg;

   // selects which write path updates the programmed delay this cycle
   typedef enum logic [1:0] {
      DSRC_NONE = 2'd0,
      DSRC_REG  = 2'd1,
      DSRC_LAT  = 2'd2
   } dly_src_e;

   // frames -> BX with floor, signed offset, saturation to [0, max_dly]
   function automatic int frames_to_dly(int frames, int ofs, int fpb, int max_dly);
      int v;
      v = frames / fpb + ofs;
      if (v < 0)
         v = 0;
      else if (v > max_dly)
         v = max_dly;
      return v;
   endfunction

endpackage

// File: rtl/bcmd_lat_conv.sv
module bcmd_lat_conv #(
   parameter int LAT_W = 10,
   parameter int OFS_W = 7,
   parameter int DLY_W = 6,
   parameter int FPB   = 6
) (
   input  logic [LAT_W-1:0]        lat_frames,
   input  logic signed [OFS_W-1:0] lat_ofs,
   output logic [DLY_W-1:0]        lat_dly
);
   localparam int MAX_DLY = (1 << DLY_W) - 1;

   if (FPB < 1) begin : g_bad_fpb
      $error("bcmd_lat_conv: FPB must be at least 1");
   end

   always_comb begin
      lat_dly = DLY_W'(bcmd_pkg::frames_to_dly(int'(lat_frames), int'(lat_ofs), FPB, MAX_DLY));
   end
endmodule

// File: rtl/bcmd_dly_ctrl.sv
module bcmd_dly_ctrl #(
   parameter int DLY_W   = 6,
   parameter int MIN_DLY = 5,
   parameter logic [DLY_W-1:0] DEF_DLY = DLY_W'(39)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [DLY_W-1:0] reg_wdata,
   input  logic             lat_wr,
   input  logic [DLY_W-1:0] lat_dly,
   output logic [DLY_W-1:0] eff_dly,
   output logic [DLY_W-1:0] blank_cnt
);
   import bcmd_pkg::*;

   localparam logic [DLY_W-1:0] MIN_V = DLY_W'(MIN_DLY);

   if (MIN_DLY < 1 || MIN_DLY >= (1 << DLY_W)) begin : g_bad_min
      $error("bcmd_dly_ctrl: MIN_DLY out of range");
   end

   function automatic logic [DLY_W-1:0] clamp_min(logic [DLY_W-1:0] v);
      return (v < MIN_V) ? MIN_V : v;
   endfunction

   dly_src_e         src;
   logic [DLY_W-1:0] prog_q;
   logic [DLY_W-1:0] prog_d;
   logic [DLY_W-1:0] eff_d;

   always_comb begin
      src = DSRC_NONE;
      if (reg_wr)
         src = DSRC_REG;
      else if (lat_wr)
         src = DSRC_LAT;
      case (src)
         DSRC_REG: prog_d = reg_wdata;
         DSRC_LAT: prog_d = lat_dly;
         default:  prog_d = prog_q;
      endcase
   end

   assign eff_d   = clamp_min(prog_d);
   assign eff_dly = clamp_min(prog_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q    <= DEF_DLY;
         blank_cnt <= clamp_min(DEF_DLY);
      end else begin
         prog_q <= prog_d;
         if (eff_d != eff_dly)
            blank_cnt <= eff_d;
         else if (blank_cnt != '0)
            blank_cnt <= blank_cnt - DLY_W'(1);
      end
   end
endmodule

// File: rtl/bcmd_bx_counter.sv
module bcmd_bx_counter #(
   parameter int ORBIT_LEN = 3564,
   parameter int BX_W      = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [BX_W-1:0] bx_now
);
   localparam logic [BX_W-1:0] LAST = BX_W'(ORBIT_LEN - 1);

   if (ORBIT_LEN < 2 || ORBIT_LEN > (1 << BX_W)) begin : g_bad_len
      $error("bcmd_bx_counter: ORBIT_LEN does not fit BX_W");
   end

   if (ORBIT_LEN == (1 << BX_W)) begin : g_pow2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bx_now <= '0;
         else
            bx_now <= bx_now + BX_W'(1);
      end
   end else begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bx_now <= '0;
         else if (bx_now == LAST)
            bx_now <= '0;
         else
            bx_now <= bx_now + BX_W'(1);
      end
   end
endmodule

// File: rtl/bcmd_ring.sv
module bcmd_ring #(
   parameter int DW = 17,
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_dly,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp;
   logic [AW-1:0] ra;

   assign ra = wp - rd_dly;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wp <= '0;
      else
         wp <= wp + AW'(1);
   end

   always_ff @(posedge clk) begin
      mem[wp] <= wr_data;
      rd_data <= mem[ra];
   end
endmodule

// File: rtl/bcmd_delay_line.sv
module bcmd_delay_line #(
   parameter int CODE_W         = 4,
   parameter int DLY_W          = 6,
   parameter int MIN_DLY        = 5,
   parameter int ORBIT_LEN      = 3564,
   parameter int FPB            = 6,
   parameter int LAT_W          = 10,
   parameter int OFS_W          = 7,
   parameter int DEF_LAT_FRAMES = 235,
   parameter int DEF_OFS        = 0,
   localparam int BX_W          = $clog2(ORBIT_LEN)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_vld,
   input  logic [CODE_W-1:0]       cmd_code,
   input  logic                    dly_wr,
   input  logic [DLY_W-1:0]        dly_wdata,
   input  logic                    lat_wr,
   input  logic [LAT_W-1:0]        lat_frames,
   input  logic signed [OFS_W-1:0] lat_ofs,
   output logic                    out_vld,
   output logic [CODE_W-1:0]       out_code,
   output logic [BX_W-1:0]         out_bx
);
   localparam int DW = 1 + CODE_W + BX_W;
   localparam logic [DLY_W-1:0] DEF_DLY =
      DLY_W'(bcmd_pkg::frames_to_dly(DEF_LAT_FRAMES, DEF_OFS, FPB, (1 << DLY_W) - 1));

   if (CODE_W < 1) begin : g_bad_code
      $error("bcmd_delay_line: CODE_W must be at least 1");
   end
   if (DLY_W < 3) begin : g_bad_dly
      $error("bcmd_delay_line: DLY_W too small");
   end

   logic [DLY_W-1:0] lat_dly;
   logic [DLY_W-1:0] eff_dly;
   logic [DLY_W-1:0] blank_cnt;
   logic [BX_W-1:0]  bx_now;
   logic [DW-1:0]    wr_word;
   logic [DW-1:0]    rd_word;
   logic             rd_vld;
   logic             pass_q;

   bcmd_lat_conv #(
      .LAT_W(LAT_W), .OFS_W(OFS_W), .DLY_W(DLY_W), .FPB(FPB)
   ) i_lat_conv (
      .lat_frames(lat_frames),
      .lat_ofs   (lat_ofs),
      .lat_dly   (lat_dly)
   );

   bcmd_dly_ctrl #(
      .DLY_W(DLY_W), .MIN_DLY(MIN_DLY), .DEF_DLY(DEF_DLY)
   ) i_dly_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (dly_wr),
      .reg_wdata(dly_wdata),
      .lat_wr   (lat_wr),
      .lat_dly  (lat_dly),
      .eff_dly  (eff_dly),
      .blank_cnt(blank_cnt)
   );

   bcmd_bx_counter #(
      .ORBIT_LEN(ORBIT_LEN), .BX_W(BX_W)
   ) i_bx_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .bx_now(bx_now)
   );

   assign wr_word = {cmd_vld, cmd_code, bx_now};

   bcmd_ring #(
      .DW(DW), .AW(DLY_W)
   ) i_ring (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_data(wr_word),
      .rd_dly (eff_dly),
      .rd_data(rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pass_q <= 1'b0;
      else
         pass_q <= (blank_cnt == '0);
   end

   assign {rd_vld, out_code, out_bx} = rd_word;
   assign out_vld = rd_vld & pass_q;
endmodule

module bcmd_delay_line_chk #(
   parameter int DLY_W     = 6,
   parameter int MIN_DLY   = 5,
   parameter int ORBIT_LEN = 3564,
   parameter int BX_W      = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dly_wr,
   input logic [DLY_W-1:0] dly_wdata,
   input logic             lat_wr,
   input logic [DLY_W-1:0] eff_dly,
   input logic [DLY_W-1:0] blank_cnt,
   input logic [BX_W-1:0]  bx_now,
   input logic             out_vld,
   input logic [BX_W-1:0]  out_bx
);
   localparam logic [BX_W-1:0]  LAST  = BX_W'(ORBIT_LEN - 1);
   localparam logic [DLY_W-1:0] MIN_V = DLY_W'(MIN_DLY);

   function automatic logic [DLY_W-1:0] cl(logic [DLY_W-1:0] v);
      return (v < MIN_V) ? MIN_V : v;
   endfunction

   // R3
   bx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bx_now <= LAST);
   // R3
   bx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bx_now == LAST) |=> (bx_now == '0));
   // R3
   bx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bx_now != LAST) |=> (bx_now == $past(bx_now) + BX_W'(1)));
   // R2
   tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_bx <= LAST));
   // R4
   min_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eff_dly >= MIN_V);
   // R7
   blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_cnt != '0) |=> !out_vld);
   // R8
   no_reblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_wr && blank_cnt == '0 && cl(dly_wdata) == eff_dly) |=> (blank_cnt == '0));
   // R9
   wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_wr && lat_wr) |=> (eff_dly == cl($past(dly_wdata))));
endmodule

bind bcmd_delay_line bcmd_delay_line_chk #(
   .DLY_W(DLY_W), .MIN_DLY(MIN_DLY), .ORBIT_LEN(ORBIT_LEN), .BX_W(BX_W)
) i_bcmd_delay_line_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dly_wr   (dly_wr),
   .dly_wdata(dly_wdata),
   .lat_wr   (lat_wr),
   .eff_dly  (eff_dly),
   .blank_cnt(blank_cnt),
   .bx_now   (bx_now),
   .out_vld  (out_vld),
   .out_bx   (out_bx)
);

// File: tb/test_bcmd_delay_line.sv
module test_bcmd_delay_line;
   localparam int CLK_PERIOD = 10;
   localparam int ORBIT      = 3564;
   localparam int MIN_D      = 5;
   localparam int MAX_D      = 63;
   localparam int HIST       = 128;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_vld = 1'b0;
   logic [3:0]        cmd_code = '0;
   logic              dly_wr = 1'b0;
   logic [5:0]        dly_wdata = '0;
   logic              lat_wr = 1'b0;
   logic [9:0]        lat_frames = '0;
   logic signed [6:0] lat_ofs = '0;
   logic              out_vld;
   logic [3:0]        out_code;
   logic [11:0]       out_bx;

   bcmd_delay_line i_bcmd_delay_line (
      .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
      .dly_wr(dly_wr), .dly_wdata(dly_wdata), .lat_wr(lat_wr),
      .lat_frames(lat_frames), .lat_ofs(lat_ofs),
      .out_vld(out_vld), .out_code(out_code), .out_bx(out_bx)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   string phase  = "R6 default";

   // behavioural reference state
   bit model_on = 1'b0;
   int n        = 0;
   int m_dly;
   int m_chg    = 0;
   bit hv [HIST];
   int hc [HIST];
   int ht [HIST];
   bit e_vld    = 1'b0;
   int e_code   = 0;
   int e_bx     = 0;

   function automatic int clamp_req(int v);
      return (v < MIN_D) ? MIN_D : v;
   endfunction

   function automatic int conv_req(int frames, int ofs);
      int v;
      v = frames / 6 + ofs;
      if (v < 0) v = 0;
      if (v > MAX_D) v = MAX_D;
      return v;
   endfunction

   task automatic fail(string req, string what, int act, int exp);
      errors++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d n=%0d", req, phase, what, act, exp, n);
   endtask

   initial m_dly = clamp_req(conv_req(235, 0));

   always @(posedge clk) begin
      if (model_on) begin
         int nd;
         n++;
         e_vld = 1'b0;
         if (n > m_chg + m_dly) begin
            e_vld  = hv[(n - m_dly) % HIST];
            e_code = hc[(n - m_dly) % HIST];
            e_bx   = ht[(n - m_dly) % HIST];
         end
         hv[n % HIST] = cmd_vld;
         hc[n % HIST] = int'(cmd_code);
         ht[n % HIST] = (n - 1) % ORBIT;
         nd = m_dly;
         if (dly_wr)
            nd = clamp_req(int'(dly_wdata));
         else if (lat_wr)
            nd = clamp_req(conv_req(int'(lat_frames), int'(lat_ofs)));
         if (nd != m_dly) begin
            m_dly = nd;
            m_chg = n;
         end
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         checks++;
         if (out_vld !== 1'b0) fail("R6", "valid in reset", int'(out_vld), 0);
      end else if (model_on && n > 0) begin
         checks++;
         if (out_vld !== e_vld) fail("R1 R7", "out_vld", int'(out_vld), int'(e_vld));
         if (e_vld && out_vld === 1'b1) begin
            checks++;
            if (int'(out_code) != e_code) fail("R1", "out_code", int'(out_code), e_code);
            checks++;
            if (int'(out_bx) != e_bx) fail("R2 R3", "out_bx", int'(out_bx), e_bx);
         end
      end
   end

   task automatic run(int cycles, int pct);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         cmd_vld  = (($urandom % 100) < pct);
         cmd_code = 4'($urandom);
      end
   endtask

   task automatic wr_dly(int v);
      @(negedge clk);
      cmd_vld = (($urandom % 100) < 40); cmd_code = 4'($urandom);
      dly_wr = 1'b1; dly_wdata = 6'(v);
      @(negedge clk);
      dly_wr = 1'b0;
      cmd_vld = (($urandom % 100) < 40); cmd_code = 4'($urandom);
   endtask

   task automatic wr_lat(int frames, int ofs, bit both, int v);
      @(negedge clk);
      cmd_vld = (($urandom % 100) < 40); cmd_code = 4'($urandom);
      lat_wr = 1'b1; lat_frames = 10'(frames); lat_ofs = 7'(ofs);
      dly_wr = both; dly_wdata = 6'(v);
      @(negedge clk);
      lat_wr = 1'b0; dly_wr = 1'b0;
      cmd_vld = (($urandom % 100) < 40); cmd_code = 4'($urandom);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n    = 1'b1;
      model_on = 1'b1;
      phase = "R6 default 39";       run(300, 30);
      phase = "R1 dense";            run(200, 95);
      phase = "R4 write 0";          wr_dly(0);  run(200, 30);
      phase = "R8 write 4 same";     wr_dly(4);  run(100, 50);
      phase = "R8 write 5 same";     wr_dly(5);  run(100, 10);
      phase = "R4 write 63";         wr_dly(63); run(250, 30);
      phase = "R5 235 frames -2";    wr_lat(235, -2, 1'b0, 0);  run(200, 30);
      phase = "R5 negative";         wr_lat(100, -30, 1'b0, 0); run(200, 30);
      phase = "R5 above max";        wr_lat(500, 10, 1'b0, 0);  run(200, 30);
      phase = "R9 both writes";      wr_lat(300, 0, 1'b1, 10);  run(200, 30);
      phase = "R7 back-to-back";     wr_dly(20); wr_dly(7); run(150, 60);
      phase = "R3 orbit wrap";       run(4000, 20);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule